// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is an 8-bit arithmetic and logic unit that works on its own accumulator register. Beside the accumulator it keeps a status byte of five condition flags. Each accepted command names an operation and carries an 8-bit operand, which may come from a register or from immediate data. On the next clock edge the block writes the new accumulator value and the new flags. The operations are add and subtract, each with or without the incoming carry, the three bitwise operations, compare, the four rotates, complement of the accumulator, and the two carry-only operations.

Commands arrive on a valid/ready stream. The block finishes every operation in a single cycle, so `in_ready` is held high at all times and never applies back-pressure. A command counts as accepted on any rising clock edge where `in_valid` is high. When `in_valid` is low the state does not change. A combinational condition vector is also provided. It reports the eight branch conditions that are derived from the current flags, so a sequencer can use it for conditional jumps, calls and returns.

Top module: `acc_alu_core`

## Requirements
- R1: While `rst_n` is low, and after it is released, `acc_o` reads 0x00 and `flags_o` reads 0x00 until the first accepted command.
- R2: `in_ready` is always 1. A command is applied at a rising edge where `in_valid` is 1. If `in_valid` is 0, `acc_o` and `flags_o` keep their values. The `in_op` encoding is: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 compare, 8 rotate left, 9 rotate right, 10 rotate left through carry, 11 rotate right through carry, 12 complement accumulator, 13 complement carry, 14 set carry, 15 no operation.
- R3: The `flags_o` bit layout is sign at bit 7, zero at bit 6, auxiliary carry at bit 4, parity at bit 2 and carry at bit 0. Bits 5, 3 and 1 always read 0. For every operation that produces a result, sign is result bit 7, zero is 1 when the result is 0x00, and parity is 1 when the result has an even number of ones.
- R4: Add computes acc+operand, and add with carry computes acc+operand+carry. Carry becomes the carry out of bit 7. Auxiliary carry becomes the carry out of bit 3.
- R5: Subtract computes acc−operand, and subtract with borrow computes acc−operand−carry. Carry becomes 1 when the full 8-bit subtraction borrows. Auxiliary carry becomes 1 when the low nibble borrows, that is, when acc[3:0] < operand[3:0] + borrow-in.
- R6: AND, OR and XOR write the bitwise result to the accumulator and clear both carry and auxiliary carry.
- R7: Compare sets every flag exactly as subtract would, and leaves the accumulator unchanged.
- R8: A plain rotate left or right moves the accumulator by one bit. The bit that leaves goes into both carry and the vacated end. No flag other than carry changes.
- R9: A rotate left or right through carry puts the old carry into the vacated end and the leaving bit into carry. No flag other than carry changes.
- R10: Complement accumulator inverts all eight accumulator bits and leaves every flag unchanged.
- R11: Complement carry inverts carry, and set carry forces carry to 1. Both leave the accumulator and all other flags unchanged.
- R12: `cond_o` bit 0 is not-zero, bit 1 zero, bit 2 no-carry, bit 3 carry, bit 4 parity-odd, bit 5 parity-even, bit 6 plus (sign 0) and bit 7 minus (sign 1). Each bit reflects the current `flags_o`.
- R13: Opcode 15 leaves both the accumulator and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, clears accumulator and flags |
| in_valid | input | 1 | Command present on `in_op` / `in_operand` |
| in_ready | output | 1 | Always 1; the block accepts a command every cycle |
| in_op | input | 4 | Operation selector (encoding in R2) |
| in_operand | input | 8 | Register or immediate operand |
| acc_o | output | 8 | Accumulator contents |
| flags_o | output | 8 | Status byte (layout in R3) |
| cond_o | output | 8 | Branch-condition vector (layout in R12) |

## Verification
No port loads the accumulator directly. Every operation therefore needs a known starting accumulator and carry, and the bench builds that state through the normal command path. It sends AND with 0x00 to clear the accumulator and carry, then OR with the wanted value, then set carry when a carry-in of 1 is needed. Each combined case follows that preamble. It crosses the edge values 0x00, 0x7F, 0x80 and 0xFF with carry-in 0 and 1, so that the nibble borrows, the wrap of a rotate through carry and the compare that leaves the accumulator unchanged can all be reached. A reference model tracks the state after every step.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB = 4'd3,
    OP_AND = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,  OP_CMP = 4'd7,
    OP_RLC = 4'd8,  OP_RRC = 4'd9,  OP_RAL = 4'd10, OP_RAR = 4'd11,
    OP_CMA = 4'd12, OP_CMC = 4'd13, OP_STC = 4'd14, OP_NOP = 4'd15
  } alu_op_e;

  localparam int FB_SIGN  = 7;
  localparam int FB_ZERO  = 6;
  localparam int FB_AUX   = 4;
  localparam int FB_PAR   = 2;
  localparam int FB_CARRY = 0;
  localparam int FLAG_W   = 8;
  localparam logic [FLAG_W-1:0] FLAG_UNUSED = 8'h2A;
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         aux
);
  localparam int NIB = 4;
  logic [W:0]   full;
  logic [NIB:0] low;

  always_comb begin
    if (sub) begin
      full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
      low  = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, cin};
    end else begin
      full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      low  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
    end
    res  = full[W-1:0];
    cout = full[W];
    aux  = low[NIB];
  end
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e           op,
  input  logic [W-1:0]      acc,
  input  logic [FLAG_W-1:0] flags,
  input  logic [W-1:0]      operand,
  output logic [W-1:0]      nxt_acc,
  output logic [FLAG_W-1:0] nxt_flags
);
  logic         carry;
  logic         use_cin;
  logic         is_sub;
  logic [W-1:0] ar_res;
  logic         ar_co;
  logic         ar_aux;

  assign carry   = flags[FB_CARRY];
  assign use_cin = (op == OP_ADC) || (op == OP_SBB);
  assign is_sub  = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);

  acc_alu_arith #(.W(W)) arith_i (
    .a(acc), .b(operand), .cin(use_cin & carry), .sub(is_sub),
    .res(ar_res), .cout(ar_co), .aux(ar_aux)
  );

  logic [W-1:0] res;
  logic         cy;
  logic         ac;
  logic         full_upd;

  always_comb begin
    nxt_acc  = acc;
    res      = acc;
    cy       = carry;
    ac       = flags[FB_AUX];
    full_upd = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        res = ar_res; nxt_acc = ar_res; cy = ar_co; ac = ar_aux; full_upd = 1'b1;
      end
      OP_CMP: begin
        res = ar_res; cy = ar_co; ac = ar_aux; full_upd = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        if (op == OP_AND)     res = acc & operand;
        else if (op == OP_OR) res = acc | operand;
        else                  res = acc ^ operand;
        nxt_acc = res; cy = 1'b0; ac = 1'b0; full_upd = 1'b1;
      end
      OP_RLC: begin nxt_acc = {acc[W-2:0], acc[W-1]}; cy = acc[W-1]; end
      OP_RRC: begin nxt_acc = {acc[0], acc[W-1:1]};   cy = acc[0];   end
      OP_RAL: begin nxt_acc = {acc[W-2:0], carry};    cy = acc[W-1]; end
      OP_RAR: begin nxt_acc = {carry, acc[W-1:1]};    cy = acc[0];   end
      OP_CMA: nxt_acc = ~acc;
      OP_CMC: cy = ~carry;
      OP_STC: cy = 1'b1;
      default: ;
    endcase

    nxt_flags = flags & ~FLAG_UNUSED;
    if (full_upd) begin
      nxt_flags[FB_SIGN] = res[W-1];
      nxt_flags[FB_ZERO] = (res == '0);
      nxt_flags[FB_AUX]  = ac;
      nxt_flags[FB_PAR]  = ~^res;
    end
    nxt_flags[FB_CARRY] = cy;
  end
endmodule

// File: rtl/acc_alu_cond.sv
module acc_alu_cond
  import acc_alu_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  output logic [7:0]        cond
);
  localparam int NPAIR = 4;
  logic [NPAIR-1:0] src;
  assign src = {flags[FB_SIGN], flags[FB_PAR], flags[FB_CARRY], flags[FB_ZERO]};

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    assign cond[2*i]   = ~src[i];
    assign cond[2*i+1] =  src[i];
  end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [3:0]   in_op,
  input  logic [W-1:0] in_operand,
  output logic [W-1:0] acc_o,
  output logic [7:0]   flags_o,
  output logic [7:0]   cond_o
);
  alu_op_e           op;
  logic [W-1:0]      acc_q, acc_d;
  logic [FLAG_W-1:0] flg_q, flg_d;

  assign op       = alu_op_e'(in_op);
  assign in_ready = 1'b1;

  acc_alu_unit #(.W(W)) unit_i (
    .op(op), .acc(acc_q), .flags(flg_q), .operand(in_operand),
    .nxt_acc(acc_d), .nxt_flags(flg_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      flg_q <= '0;
    end else if (in_valid) begin
      acc_q <= acc_d;
      flg_q <= flg_d;
    end
  end

  acc_alu_cond cond_i (.flags(flg_q), .cond(cond_o));

  assign acc_o   = acc_q;
  assign flags_o = flg_q;

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(acc_o) && $stable(flags_o)));
  a_r3_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o & FLAG_UNUSED) == 8'h00);
  a_r7_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 4'd7) |=> $stable(acc_o));
  a_r8_rot_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op[3:2] == 2'b10) |=> (flags_o[7:1] == $past(flags_o[7:1])));
  a_r11_stc_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 4'd14) |=> flags_o[0]);
  a_r11_cmc_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 4'd13) |=> (flags_o[0] != $past(flags_o[0])));
  a_r12_zero_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_o[1] == flags_o[6]) && (cond_o[0] != flags_o[6]));
  a_r13_nop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 4'd15) |=> ($stable(acc_o) && $stable(flags_o)));
endmodule

// File: tb/acc_alu_core_tb_top.sv
module acc_alu_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_op = 4'd15;
  logic [7:0] in_operand = 8'h00;
  logic [7:0] acc_o, flags_o, cond_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] m_acc = 8'h00;
  logic [7:0] m_fl  = 8'h00;

  always #10 clk = ~clk;

  acc_alu_core dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_operand(in_operand),
    .acc_o(acc_o), .flags_o(flags_o), .cond_o(cond_o)
  );

  // entry: {op[3:0], start acc[7:0], operand[7:0], carry-in}
  localparam int NV = 20;
  localparam logic [20:0] VEC [NV] = '{
    {4'd0,  8'h7F, 8'h01, 1'b0}, {4'd0,  8'hFF, 8'h01, 1'b0},
    {4'd1,  8'hFF, 8'h00, 1'b1}, {4'd1,  8'h7F, 8'h80, 1'b1},
    {4'd2,  8'h00, 8'h01, 1'b0}, {4'd2,  8'h80, 8'h7F, 1'b0},
    {4'd3,  8'h00, 8'h00, 1'b1}, {4'd3,  8'hFF, 8'hFF, 1'b1},
    {4'd4,  8'hFF, 8'h80, 1'b1}, {4'd5,  8'h00, 8'h00, 1'b1},
    {4'd6,  8'hFF, 8'h7F, 1'b0}, {4'd7,  8'h7F, 8'h80, 1'b0},
    {4'd7,  8'h80, 8'h80, 1'b1}, {4'd8,  8'h80, 8'h00, 1'b0},
    {4'd9,  8'h01, 8'h00, 1'b0}, {4'd10, 8'h7F, 8'h00, 1'b1},
    {4'd11, 8'h00, 8'h00, 1'b1}, {4'd12, 8'h80, 8'h00, 1'b1},
    {4'd13, 8'hFF, 8'h00, 1'b1}, {4'd14, 8'h7F, 8'h00, 1'b0}
  };

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:         return "R4";
      4'd2, 4'd3:         return "R5";
      4'd4, 4'd5, 4'd6:   return "R6";
      4'd7:               return "R7";
      4'd8, 4'd9:         return "R8";
      4'd10, 4'd11:       return "R9";
      4'd12:              return "R10";
      4'd13, 4'd14:       return "R11";
      default:            return "R13";
    endcase
  endfunction

  function automatic logic [7:0] szp(input logic [7:0] r, input bit aux, input bit cy);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(r[i]);
    return {r[7], (r == 8'h00), 1'b0, aux, 1'b0, (ones % 2 == 0), 1'b0, cy};
  endfunction

  // reference model, R3-R11 and R13
  task automatic model(input logic [3:0] op, input logic [7:0] b);
    int a = int'(m_acc);
    int bi = int'(b);
    int c = int'(m_fl[0]);
    int v;
    case (op)
      4'd0, 4'd1: begin
        if (op == 4'd0) c = 0;
        v = a + bi + c;
        m_fl = szp(v[7:0], ((a % 16) + (bi % 16) + c) > 15, v > 255);
        m_acc = v[7:0];
      end
      4'd2, 4'd3, 4'd7: begin
        if (op != 4'd3) c = 0;
        v = a - bi - c;
        m_fl = szp(v[7:0], (a % 16) < ((bi % 16) + c), v < 0);
        if (op != 4'd7) m_acc = v[7:0];
      end
      4'd4: begin m_acc = m_acc & b; m_fl = szp(m_acc, 0, 0); end
      4'd5: begin m_acc = m_acc | b; m_fl = szp(m_acc, 0, 0); end
      4'd6: begin m_acc = m_acc ^ b; m_fl = szp(m_acc, 0, 0); end
      4'd8:  begin m_fl[0] = m_acc[7]; m_acc = (m_acc << 1) | (m_acc >> 7); end
      4'd9:  begin m_fl[0] = m_acc[0]; m_acc = (m_acc >> 1) | (m_acc << 7); end
      4'd10: begin m_fl[0] = m_acc[7]; m_acc = (m_acc << 1) | 8'(c); end
      4'd11: begin m_fl[0] = m_acc[0]; m_acc = (m_acc >> 1) | (8'(c) << 7); end
      4'd12: m_acc = ~m_acc;
      4'd13: m_fl[0] = ~m_fl[0];
      4'd14: m_fl[0] = 1'b1;
      default: ;
    endcase
  endtask

  task automatic compare(input string req);
    logic [7:0] ec;
    ec = {m_fl[7], ~m_fl[7], m_fl[2], ~m_fl[2], m_fl[0], ~m_fl[0], m_fl[6], ~m_fl[6]};
    checks++;
    if (acc_o !== m_acc || flags_o !== m_fl) begin
      errors++;
      $display("FAIL %s acc=%02h flags=%02h expected acc=%02h flags=%02h",
               req, acc_o, flags_o, m_acc, m_fl);
    end
    checks++;
    if (cond_o !== ec || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R12 cond=%02h ready=%0b expected cond=%02h ready=1", cond_o, in_ready, ec);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_operand = b;
    @(negedge clk);
    in_valid = 1'b0;
    model(op, b);
    compare(req_of(op));
  endtask

  task automatic preset(input logic [7:0] a, input bit cin);
    apply(4'd4, 8'h00);
    apply(4'd5, a);
    if (cin) apply(4'd14, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (acc_o !== 8'h00 || flags_o !== 8'h00) begin
      errors++;
      $display("FAIL R1 acc=%02h flags=%02h expected 00 00 in reset", acc_o, flags_o);
    end
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    for (int i = 0; i < NV; i++) begin
      preset(VEC[i][16:9], VEC[i][0]);
      apply(VEC[i][20:17], VEC[i][8:1]);
    end

    for (int op = 0; op < 15; op++) begin
      foreach (VEC[k]) begin
        preset(VEC[k][16:9], VEC[k][0]);
        apply(4'(op), VEC[k][8:1]);
      end
    end

    for (int n = 0; n < 600; n++) begin
      logic [3:0] op = 4'($urandom_range(0, 15));
      if ((n % 8) == 0) preset(8'($urandom), 1'($urandom));
      apply(op, 8'($urandom));
    end

    // R2: held command with valid low changes nothing
    preset(8'h3C, 1'b1);
    @(negedge clk);
    in_valid = 1'b0; in_op = 4'd0; in_operand = 8'h55;
    @(negedge clk);
    @(negedge clk);
    compare("R2");

    // R13: opcode 15 with nonzero operand
    apply(4'd15, 8'hA5);

    // R1: reset in mid-run
    preset(8'hFF, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    m_acc = 8'h00; m_fl = 8'h00;
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule